// File: doc/BRIEF.md
# Function Power State Register

This block keeps the power state of a single peripheral function in a 2-bit field that software reaches through a small register bus. Two states are supported: full power (D0, code 00b) and D3hot (code 11b). The other two codes are accepted on the bus but change nothing. The current state decides three things. It gates the function's memory-space traffic, it masks the function's interrupt, and it triggers a one-cycle warm reset of the function when software brings the function back from D3hot to D0.

Register-bus (configuration) reads always work, in either state. A second register returns a fixed capability identifier byte. The state field is cleared only by the always-on reset. Neither the function's own warm reset nor anything else on the bus clears it.

Top module: `pwrStateReg`

## Requirements
- R1: After the always-on reset `auxRstN`, the state is D0 and a read of the state register (address 0) returns 16'h0000.
- R2: A write to address 0 whose bits 1:0 are 00b or 11b sets the state to that code. A read of address 0 returns the state in bits 1:0.
- R3: A write to address 0 whose bits 1:0 are 01b or 10b completes but leaves the state unchanged.
- R4: Bits 15:2 of address 0 read as zero whatever was written to them.
- R5: In D3hot, a memory request (`memReq`) is not passed to the function (`fnMemReq` low) and is refused: `memAck` is low, `memErr` is high and `memRdData` is all ones. In D0, `fnMemReq` and `memAck` follow `memReq`, `memErr` is low and `memRdData` equals `fnRdData`.
- R6: Register reads of both addresses return correct data in D3hot as well as in D0.
- R7: `irqOut` equals `fnIrq` in D0 and is held low in D3hot.
- R8: A write that moves the state from D3hot to D0 raises `softRst` for exactly one cycle, in the cycle after the write.
- R9: A write that leaves the state unchanged, or that moves it from D0 to D3hot, raises no `softRst` pulse.
- R10: The `softRst` pulse does not clear the state register. The state stays D0 after the pulse.
- R11: A read of address 1 returns 16'h000A. Writes to address 1 change neither that value nor the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| auxRstN | input | 1 | Always-on reset, active low |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register address (0 state, 1 capability ID) |
| cfgWrData | input | 16 | Register write data |
| cfgRdData | output | 16 | Register read data, combinational |
| memReq | input | 1 | Memory-space request from host |
| memAck | output | 1 | Memory request claimed |
| memErr | output | 1 | Memory request refused |
| memRdData | output | 32 | Memory read data to host |
| fnMemReq | output | 1 | Memory request passed to function |
| fnRdData | input | 32 | Read data from function |
| fnIrq | input | 1 | Interrupt request from function |
| irqOut | output | 1 | Gated interrupt |
| softRst | output | 1 | One-cycle warm reset of function |

## Verification
Every one of the four write codes is applied from both starting states. Each is paired with reserved-bit patterns of all zeros and all ones. This separates accepted codes from discarded ones, separates state changes that pulse from those that do not, and confirms that upper bits never leak into the readback. In each state, every combination of `memReq` and `fnIrq` is applied with several `fnRdData` words. This shows that gating depends on the state alone and that pass-through data is not corrupted. Writes to the identifier address are issued in both states and show that it is fixed.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic [1:0] {
    PS_D0    = 2'b00,
    PS_RSV1  = 2'b01,
    PS_RSV2  = 2'b10,
    PS_D3HOT = 2'b11
  } pwrState_e;

  typedef struct packed {
    logic      load;
    pwrState_e nextState;
    logic      wake;
  } ctrlStrobe_t;
endpackage

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter logic [ADDR_W-1:0] PM_ADDR = '0
) (
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [1:0]        reqCode,
  input  pwrState_e         curState,
  output ctrlStrobe_t       strobe
);
  logic      pmWrite;
  logic      codeLegal;
  pwrState_e reqState;

  always_comb begin
    reqState  = pwrState_e'(reqCode);
    pmWrite   = cfgWrEn && (cfgAddr == PM_ADDR);
    codeLegal = (reqState == PS_D0) || (reqState == PS_D3HOT);
    strobe.load      = pmWrite && codeLegal && (reqState != curState);
    strobe.nextState = reqState;
    strobe.wake      = strobe.load && (curState == PS_D3HOT) && (reqState == PS_D0);
  end
endmodule

// File: rtl/pwr_state_dp.sv
module pwr_state_dp
  import pwr_state_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int REG_W  = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] PM_ADDR  = '0,
  parameter logic [ADDR_W-1:0] CAP_ADDR = 1,
  parameter logic [7:0] CAP_ID = 8'h0A
) (
  input  logic              clk,
  input  logic              auxRstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output logic [REG_W-1:0]  cfgRdData,
  output pwrState_e         curState,
  input  logic              memReq,
  output logic              memAck,
  output logic              memErr,
  output logic [DATA_W-1:0] memRdData,
  output logic              fnMemReq,
  input  logic [DATA_W-1:0] fnRdData,
  input  logic              fnIrq,
  output logic              irqOut,
  output logic              softRst
);
  localparam int PAD_W = REG_W - 2;
  localparam int CAP_PAD_W = REG_W - 8;

  pwrState_e stateQ;
  logic      wakeQ;
  logic      fullPower;

  always_ff @(posedge clk or negedge auxRstN) begin
    if (!auxRstN) begin
      stateQ <= PS_D0;
      wakeQ  <= 1'b0;
    end else begin
      if (strobe.load) stateQ <= strobe.nextState;
      wakeQ <= strobe.wake;
    end
  end

  always_comb begin
    fullPower = (stateQ == PS_D0);
    fnMemReq  = memReq && fullPower;
    memAck    = memReq && fullPower;
    memErr    = memReq && !fullPower;
    memRdData = fullPower ? fnRdData : {DATA_W{1'b1}};
    irqOut    = fnIrq && fullPower;
    if (cfgAddr == PM_ADDR)       cfgRdData = {{PAD_W{1'b0}}, stateQ};
    else if (cfgAddr == CAP_ADDR) cfgRdData = {{CAP_PAD_W{1'b0}}, CAP_ID};
    else                          cfgRdData = '0;
  end

  assign curState = stateQ;
  assign softRst  = wakeQ;
endmodule

// File: rtl/pwrStateReg.sv
module pwrStateReg
  import pwr_state_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int REG_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              auxRstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [REG_W-1:0]  cfgWrData,
  output logic [REG_W-1:0]  cfgRdData,
  input  logic              memReq,
  output logic              memAck,
  output logic              memErr,
  output logic [DATA_W-1:0] memRdData,
  output logic              fnMemReq,
  input  logic [DATA_W-1:0] fnRdData,
  input  logic              fnIrq,
  output logic              irqOut,
  output logic              softRst
);
  localparam logic [ADDR_W-1:0] PM_ADDR  = '0;
  localparam logic [ADDR_W-1:0] CAP_ADDR = 1;

  ctrlStrobe_t strobe;
  pwrState_e   curState;
  logic        unusedUpper;

  assign unusedUpper = ^cfgWrData[REG_W-1:2];

  pwr_state_ctrl #(.ADDR_W(ADDR_W), .PM_ADDR(PM_ADDR)) ctrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .reqCode(cfgWrData[1:0]),
    .curState(curState), .strobe(strobe)
  );

  pwr_state_dp #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W),
    .PM_ADDR(PM_ADDR), .CAP_ADDR(CAP_ADDR), .CAP_ID(8'h0A)
  ) dp (
    .clk(clk), .auxRstN(auxRstN), .strobe(strobe), .cfgAddr(cfgAddr),
    .cfgRdData(cfgRdData), .curState(curState), .memReq(memReq),
    .memAck(memAck), .memErr(memErr), .memRdData(memRdData),
    .fnMemReq(fnMemReq), .fnRdData(fnRdData), .fnIrq(fnIrq),
    .irqOut(irqOut), .softRst(softRst)
  );
endmodule

// File: rtl/pwrStateReg_checker.sv
module pwrStateReg_checker #(
  parameter int ADDR_W = 2,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              auxRstN,
  input logic              cfgWrEn,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [REG_W-1:0]  cfgWrData,
  input logic [REG_W-1:0]  cfgRdData,
  input logic [1:0]        curState,
  input logic              memReq,
  input logic              fnMemReq,
  input logic              memErr,
  input logic              fnIrq,
  input logic              irqOut,
  input logic              softRst
);
  // R3: discarded codes leave the state alone
  assert_rsv_code_ignored_R3: assert property (@(posedge clk) disable iff (!auxRstN)
    (cfgWrEn && cfgAddr == '0 && (cfgWrData[1:0] == 2'b01 || cfgWrData[1:0] == 2'b10))
      |=> $stable(curState));

  // R5: memory traffic refused outside D0
  assert_mem_gated_R5: assert property (@(posedge clk) disable iff (!auxRstN)
    (memReq && curState == 2'b11) |-> (!fnMemReq && memErr));

  // R7: interrupt only in D0
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!auxRstN)
    irqOut |-> (fnIrq && curState == 2'b00));

  // R8: pulse only after leaving D3hot
  assert_wake_source_R8: assert property (@(posedge clk) disable iff (!auxRstN)
    softRst |-> ($past(curState) == 2'b11 && curState == 2'b00));

  // R8: pulse lasts one cycle
  assert_wake_single_R8: assert property (@(posedge clk) disable iff (!auxRstN)
    softRst |=> !softRst);

  // R9: D0 to D3hot gives no pulse
  assert_no_sleep_pulse_R9: assert property (@(posedge clk) disable iff (!auxRstN)
    ($past(curState) == 2'b00) |-> !softRst);

  // R11: identifier is fixed
  assert_cap_fixed_R11: assert property (@(posedge clk) disable iff (!auxRstN)
    (cfgAddr == 2'd1) |-> (cfgRdData == 16'h000A));
endmodule

bind pwrStateReg pwrStateReg_checker #(.ADDR_W(ADDR_W), .REG_W(REG_W)) chk (
  .clk(clk), .auxRstN(auxRstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .curState(curState),
  .memReq(memReq), .fnMemReq(fnMemReq), .memErr(memErr), .fnIrq(fnIrq),
  .irqOut(irqOut), .softRst(softRst)
);

// File: tb/pwrStateReg_test.sv
`timescale 1ns/1ps
module pwrStateReg_test;
  logic        clk = 1'b0;
  logic        auxRstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = 2'd0;
  logic [15:0] cfgWrData = 16'h0;
  logic [15:0] cfgRdData;
  logic        memReq = 1'b0;
  logic        memAck, memErr, fnMemReq, irqOut, softRst;
  logic [31:0] memRdData;
  logic [31:0] fnRdData = 32'h0;
  logic        fnIrq = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0] model = 2'b00;

  always #10 clk = ~clk;

  pwrStateReg uut (
    .clk(clk), .auxRstN(auxRstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .memReq(memReq),
    .memAck(memAck), .memErr(memErr), .memRdData(memRdData),
    .fnMemReq(fnMemReq), .fnRdData(fnRdData), .fnIrq(fnIrq),
    .irqOut(irqOut), .softRst(softRst)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(logic [1:0] a, string req, logic [15:0] exp);
    cfgAddr = a;
    #1;
    check(req, {16'h0, cfgRdData}, {16'h0, exp});
  endtask

  // Write on one edge, sample at the next falling edge and the one after.
  task automatic writeReg(logic [1:0] a, logic [15:0] d);
    logic [1:0] prev;
    logic       expPulse;
    prev = model;
    expPulse = 1'b0;
    if (a == 2'd0 && (d[1:0] == 2'b00 || d[1:0] == 2'b11)) begin
      expPulse = (prev == 2'b11 && d[1:0] == 2'b00);
      model = d[1:0];
    end
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    check(expPulse ? "R8 pulse" : "R9 no pulse", {31'h0, softRst}, {31'h0, expPulse});
    readReg(2'd0, "R2/R3/R4 state readback", {14'h0, model});
    @(negedge clk);
    check("R8 single cycle", {31'h0, softRst}, 32'h0);
    readReg(2'd0, "R10 state kept after pulse", {14'h0, model});
    readReg(2'd1, "R11 cap id", 16'h000A);
  endtask

  task automatic sweepGating(string tag);
    logic [31:0] pats [3];
    pats[0] = 32'h0000_0000; pats[1] = 32'hA5C3_0F96; pats[2] = 32'hFFFF_FFFE;
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 4; k++) begin
        memReq = k[0]; fnIrq = k[1]; fnRdData = pats[p];
        #1;
        if (model == 2'b00) begin
          check("R5 fnMemReq D0", {31'h0, fnMemReq}, {31'h0, k[0]});
          check("R5 memAck D0", {31'h0, memAck}, {31'h0, k[0]});
          check("R5 memErr D0", {31'h0, memErr}, 32'h0);
          check("R5 data D0", memRdData, pats[p]);
          check("R7 irq D0", {31'h0, irqOut}, {31'h0, k[1]});
        end else begin
          check("R5 fnMemReq D3", {31'h0, fnMemReq}, 32'h0);
          check("R5 memAck D3", {31'h0, memAck}, 32'h0);
          check("R5 memErr D3", {31'h0, memErr}, {31'h0, k[0]});
          check("R5 data D3", memRdData, 32'hFFFF_FFFF);
          check("R7 irq D3", {31'h0, irqOut}, 32'h0);
        end
      end
    end
    memReq = 1'b0; fnIrq = 1'b0;
    readReg(2'd0, {"R6 cfg read ", tag}, {14'h0, model});
    readReg(2'd1, {"R6 cap read ", tag}, 16'h000A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    auxRstN = 1'b1;
    @(negedge clk);
    readReg(2'd0, "R1 reset state", 16'h0000);
    check("R1 no pulse", {31'h0, softRst}, 32'h0);
    sweepGating("D0");
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        for (int r = 0; r < 2; r++) begin
          writeReg(2'd0, s ? 16'h0003 : 16'h0000);
          writeReg(2'd0, {r ? 14'h3FFF : 14'h0, c[1:0]});
          sweepGating(model == 2'b00 ? "D0" : "D3");
        end
      end
    end
    writeReg(2'd0, 16'h0003);
    writeReg(2'd1, 16'hFFFF);
    writeReg(2'd1, 16'h0000);
    writeReg(2'd0, 16'h0000);
    writeReg(2'd1, 16'h00FC);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule